// File: doc/BRIEF.md
# Wall-Clock Calendar Counter with Posted Writes

This block keeps the time of day and the calendar date. It advances by one second on each single-cycle `sec_tick` pulse. Seconds carry into minutes, minutes into hours, hours into the day of month, days into the month and months into the year. The live values are presented as two packed words. `time_reg` holds hours, minutes and seconds. `date_reg` holds day, month, a 6-bit year offset and a leap flag.

Software changes either word with a one-cycle write strobe, and `wr_is_date` selects which word is written. The write is posted. The value is held in a shadow register, and the matching busy flag rises on the next clock. The running counters keep advancing on their old values. On the `COMMIT_TICKS`-th seconds tick after the write, the shadow value replaces the counters and the busy flag drops.

Software is expected to poll until both busy flags are clear before it issues another write. The block ignores any write that arrives while either flag is set.

Top module: `rtc_calendar`

## Requirements
- R1: After reset `time_reg` is 0 (00:00:00) and `date_reg` is 0x00000101 (day 1, month 1, year offset 0, leap flag 0), with both busy flags low.
- R2: The `time_reg` fields are seconds in [5:0], minutes in [13:8] and hours in [20:16], and all other bits read 0. On each tick seconds step by one. Seconds and minutes wrap from 59 to 0 and carry, and hours wrap from 23 to 0 and carry into the date.
- R3: The `date_reg` fields are day in [4:0], month 1..12 in [11:8], year offset in [21:16] and leap flag in bit 22, and all other bits read 0. A day carry past the month's length sets the day to 1 and advances the month. April, June, September and November have 30 days, and the other months except February have 31.
- R4: February has 29 days when the leap flag is 1 and 28 days when it is 0.
- R5: A carry out of month 12 sets the month to 1 and increments the year offset, which wraps from 63 to 0. The leap flag is then recomputed as 1 exactly when the new year offset mod 4 equals 2.
- R6: A write with `wr_is_date`=0 while both busy flags are low makes `time_busy` high from the next clock. Until the commit, `time_reg` keeps counting from its old value, and no register changes on a cycle without a tick.
- R7: A posted write commits on the `COMMIT_TICKS`-th tick after it was accepted. On that tick the written fields replace the counter fields with no increment. The busy flag is low from the following clock.
- R8: A write with `wr_is_date`=1 behaves the same way using `date_busy`. The written leap flag is loaded as given and decides February's length.
- R9: A write that arrives while either busy flag is high is discarded, and at most one busy flag is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Write strobe |
| wr_is_date | input | 1 | Write target: 0 selects the time word, 1 selects the date word |
| wr_data | input | 23 | Value to write, in the packed layout of the target word |
| time_reg | output | 32 | Live packed hours, minutes and seconds |
| date_reg | output | 32 | Live packed day, month, year offset and leap flag |
| time_busy | output | 1 | A time write is pending |
| date_busy | output | 1 | A date write is pending |

## Verification
The hardest cases to reach are the carry chains that end at a month or year boundary: 23:59:59 on day 28, 29, 30 or 31, and 31 December at year offset 63. Reaching them by counting would take millions of ticks.

The stimulus reaches them through the block's own posted writes. It first commits a chosen date, then commits 23:59:59, and then applies one more tick. During each commit window the bench also checks that the old values keep running and that a second write is dropped.

// File: rtl/rtc_calendar.sv
module rtc_calendar #(
  parameter int COMMIT_TICKS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sec_tick,
  input  logic        wr_en,
  input  logic        wr_is_date,
  input  logic [22:0] wr_data,
  output logic [31:0] time_reg,
  output logic [31:0] date_reg,
  output logic        time_busy,
  output logic        date_busy
);
  localparam int CW = (COMMIT_TICKS < 2) ? 1 : $clog2(COMMIT_TICKS);

  logic [5:0]    sec, mins, yr;
  logic [4:0]    hr, day, mlen;
  logic [3:0]    mon;
  logic          leap;
  logic [22:0]   shadow;
  logic [CW-1:0] cnt;

  wire any_busy = time_busy | date_busy;
  wire commit   = sec_tick & any_busy & (cnt == CW'(COMMIT_TICKS - 1));
  wire load_t   = commit & time_busy;
  wire load_d   = commit & date_busy;
  wire sec_w    = sec >= 6'd59;
  wire min_w    = mins >= 6'd59;
  wire hr_w     = hr >= 5'd23;
  wire roll_day = sec_tick & ~load_t & sec_w & min_w & hr_w;
  wire day_end  = day >= mlen;
  wire [5:0] yr_n = yr + 6'd1;

  always_comb begin
    case (mon)
      4'd4, 4'd6, 4'd9, 4'd11: mlen = 5'd30;
      4'd2:                    mlen = leap ? 5'd29 : 5'd28;
      default:                 mlen = 5'd31;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec <= '0; mins <= '0; hr <= '0;
      day <= 5'd1; mon <= 4'd1; yr <= '0; leap <= 1'b0;
    end else begin
      if (load_t) begin
        sec <= shadow[5:0]; mins <= shadow[13:8]; hr <= shadow[20:16];
      end else if (sec_tick) begin
        sec <= sec_w ? 6'd0 : sec + 6'd1;
        if (sec_w) begin
          mins <= min_w ? 6'd0 : mins + 6'd1;
          if (min_w) hr <= hr_w ? 5'd0 : hr + 5'd1;
        end
      end
      if (load_d) begin
        day <= shadow[4:0]; mon <= shadow[11:8]; yr <= shadow[21:16]; leap <= shadow[22];
      end else if (roll_day) begin
        day <= day_end ? 5'd1 : day + 5'd1;
        if (day_end) begin
          if (mon >= 4'd12) begin
            mon  <= 4'd1;
            yr   <= yr_n;
            leap <= (yr_n[1:0] == 2'd2);
          end else begin
            mon <= mon + 4'd1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_busy <= 1'b0; date_busy <= 1'b0; shadow <= '0; cnt <= '0;
    end else if (wr_en && !any_busy) begin
      time_busy <= ~wr_is_date;
      date_busy <= wr_is_date;
      shadow    <= wr_data;
      cnt       <= '0;
    end else if (commit) begin
      time_busy <= 1'b0;
      date_busy <= 1'b0;
    end else if (sec_tick && any_busy) begin
      cnt <= cnt + CW'(1);
    end
  end

  assign time_reg = {11'b0, hr, 2'b0, mins, 2'b0, sec};
  assign date_reg = {9'b0, leap, yr, 4'b0, mon, 3'b0, day};

  AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(time_busy && date_busy)); // R9
  AST_TIME_WRITE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !time_busy && !date_busy && !wr_is_date |=> time_busy); // R6
  AST_TIME_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    time_busy && !sec_tick |=> time_busy); // R7
  AST_DATE_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    date_busy && !sec_tick |=> date_busy); // R8
  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && !time_busy && sec < 6'd59 |=> sec == $past(sec) + 6'd1); // R2
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> $stable(time_reg) && $stable(date_reg)); // R6
endmodule

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;
  localparam int N = 3;
  logic clk = 1'b0, rst_n = 1'b0, sec_tick = 1'b0, wr_en = 1'b0, wr_is_date = 1'b0;
  logic [22:0] wr_data = '0;
  logic [31:0] time_reg, date_reg;
  logic time_busy, date_busy;

  always #10 clk = ~clk;

  rtc_calendar #(.COMMIT_TICKS(N)) u0 (.*);

  typedef struct { logic [31:0] t; logic [31:0] d; logic [1:0] b; string tag; } exp_t;
  exp_t q[$];
  int tests = 0, fails = 0;
  bit done = 0;

  int m_s, m_m, m_h, m_day, m_mon, m_yr, m_leap, m_cnt;
  bit m_tb, m_db;
  logic [22:0] m_sh;

  function automatic logic [31:0] pk_t(int h, int m, int s);
    return {11'b0, 5'(h), 2'b0, 6'(m), 2'b0, 6'(s)};
  endfunction
  function automatic logic [31:0] pk_d(int lp, int y, int mo, int dy);
    return {9'b0, 1'(lp), 6'(y), 4'b0, 4'(mo), 3'b0, 5'(dy)};
  endfunction
  function automatic int mlen(int mo, int lp);
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    if (mo == 2) return lp ? 29 : 28;
    return 31;
  endfunction

  task automatic push(string tag);
    exp_t e;
    e.t = pk_t(m_h, m_m, m_s); e.d = pk_d(m_leap, m_yr, m_mon, m_day);
    e.b = {m_tb, m_db}; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic model_tick();
    bit ct = m_tb && m_cnt == N - 1;
    bit cd = m_db && m_cnt == N - 1;
    bit rday = 0;
    if (ct) begin
      m_s = m_sh[5:0]; m_m = m_sh[13:8]; m_h = m_sh[20:16];
    end else begin
      rday = (m_s == 59 && m_m == 59 && m_h == 23);
      m_s = (m_s + 1) % 60;
      if (m_s == 0) begin
        m_m = (m_m + 1) % 60;
        if (m_m == 0) m_h = (m_h + 1) % 24;
      end
    end
    if (cd) begin
      m_day = m_sh[4:0]; m_mon = m_sh[11:8]; m_yr = m_sh[21:16]; m_leap = m_sh[22];
    end else if (rday) begin
      if (m_day == mlen(m_mon, m_leap)) begin
        m_day = 1;
        if (m_mon == 12) begin
          m_mon = 1; m_yr = (m_yr + 1) % 64; m_leap = (m_yr % 4 == 2);
        end else m_mon++;
      end else m_day++;
    end
    if (ct || cd) begin m_tb = 0; m_db = 0; end
    else if (m_tb || m_db) m_cnt++;
  endtask

  task automatic idle(string tag);
    @(negedge clk); sec_tick = 0; wr_en = 0; push(tag);
  endtask
  task automatic tick(string tag);
    @(negedge clk); sec_tick = 1; wr_en = 0; model_tick(); push(tag);
  endtask
  task automatic wr(bit isd, logic [22:0] v, string tag);
    @(negedge clk); sec_tick = 0; wr_en = 1; wr_is_date = isd; wr_data = v;
    if (!m_tb && !m_db) begin m_tb = !isd; m_db = isd; m_sh = v; m_cnt = 0; end
    push(tag);
  endtask
  task automatic set_all(logic [31:0] d, logic [31:0] t, string tag);
    wr(1, d[22:0], "R8");
    idle("R8");
    for (int i = 0; i < N; i++) tick(tag);
    wr(0, t[22:0], "R6");
    for (int i = 0; i < N; i++) tick("R7");
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        tests++;
        if (time_reg !== e.t || date_reg !== e.d || {time_busy, date_busy} !== e.b) begin
          fails++;
          $display("FAIL %s: time=%h date=%h busy=%b expected time=%h date=%h busy=%b",
                   e.tag, time_reg, date_reg, {time_busy, date_busy}, e.t, e.d, e.b);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog R1: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : driver
    m_s = 0; m_m = 0; m_h = 0; m_day = 1; m_mon = 1; m_yr = 0; m_leap = 0;
    m_cnt = 0; m_tb = 0; m_db = 0; m_sh = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle("R1");
    // R6/R7: posted time write, old counters keep running
    wr(0, pk_t(23, 59, 58), "R6");
    idle("R6");
    tick("R6");
    tick("R7");
    tick("R7");
    tick("R2");
    tick("R2");
    // R9: a second write during busy is dropped
    wr(0, pk_t(5, 6, 7), "R9");
    wr(1, pk_d(1, 40, 7, 9), "R9");
    for (int i = 0; i < N; i++) tick("R9");
    idle("R9");
    // R2 minute carry only
    set_all(pk_d(0, 5, 1, 31), pk_t(1, 2, 59), "R8");
    tick("R2");
    // R3: 31-day month rollover
    set_all(pk_d(0, 5, 1, 31), pk_t(23, 59, 59), "R8");
    tick("R3");
    // R3: 30-day month rollover
    set_all(pk_d(0, 5, 4, 30), pk_t(23, 59, 59), "R8");
    tick("R3");
    // R4: February non-leap and leap
    set_all(pk_d(0, 5, 2, 28), pk_t(23, 59, 59), "R8");
    tick("R4");
    set_all(pk_d(1, 6, 2, 28), pk_t(23, 59, 59), "R8");
    tick("R4");
    set_all(pk_d(1, 6, 2, 29), pk_t(23, 59, 59), "R4");
    tick("R4");
    // R5: year rollover and leap recompute, and wrap at 63
    set_all(pk_d(0, 1, 12, 31), pk_t(23, 59, 59), "R8");
    tick("R5");
    set_all(pk_d(1, 63, 12, 31), pk_t(23, 59, 59), "R8");
    tick("R5");
    tick("R2");
    repeat (2) idle("R6");
    wait (q.size() == 0);
    @(posedge clk); #6;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule